// File: doc/BRIEF.md
# Binary32 NaN Propagation Selector

When a two-input floating-point operation has at least one NaN operand, this block chooses which NaN the operation returns. It takes two binary32 operands, sorts each into quiet NaN, signaling NaN or non-NaN, and picks one of them by a NaN-priority rule chosen with a select input. The chosen operand is quieted if it is signaling. A default-NaN enable replaces any chosen value with a fixed default NaN. The block also keeps a sticky invalid-operation flag. A signaling operand sets it, and only a clear strobe resets it.

A polarity input picks which value of the fraction's top bit marks a signaling NaN. This one input therefore covers both conventions in use. The result is registered and appears one cycle after the input strobe, together with an output valid. Arithmetic on operands that are not NaNs is outside the scope of this block.

Top module: `nanprop_sel`

## Requirements
- R1: While reset is asserted and after it, with no strobe yet applied, valid_o, res_o and invalid_o are all zero.
- R2: valid_o is high exactly in the cycle after valid_i is high, and res_o carries the result of that strobe. Without a strobe, res_o holds its value.
- R3: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are not zero. With snan_one_i=0 a NaN is signaling when bit 22 is 0 and quiet when bit 22 is 1. With snan_one_i=1 these two meanings are swapped.
- R4: A chosen signaling NaN is quieted before output. With snan_one_i=0 this sets bit 22 and keeps the other bits. With snan_one_i=1 the output becomes the default NaN. A chosen quiet NaN passes through unchanged.
- R5: The default NaN is 0x7FC00000 when snan_one_i=0 and 0x7FBFFFFF when snan_one_i=1. When dnan_en_i=1 the result is the default NaN whatever the operands are.
- R6: With rule_i=0 (rule_i=3 behaves the same), the result is the first match in this order: a if signaling, b if signaling, a if quiet, otherwise b.
- R7: With rule_i=1, the result is a if a is any NaN, otherwise b.
- R8: With rule_i=2, the rule is as follows. A signaling NaN paired with a quiet NaN returns the quiet one. Two NaNs of the same kind return the one with the larger significand. A single NaN paired with a non-NaN returns that NaN.
- R9: The larger-significand test compares bits 30:0 of both operands. If they are equal, a counts as larger only when its full 32-bit value is the smaller one, which means a is positive and b is negative.
- R10: invalid_o is set after any strobe with a signaling operand, and this includes default-NaN mode. Strobes whose NaNs are all quiet leave it unchanged.
- R11: invalid_o is sticky until clr_i is high. If a clear and a signaling strobe arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| rule_i | input | 2 | NaN-priority rule select |
| snan_one_i | input | 1 | 1: fraction top bit set means signaling |
| dnan_en_i | input | 1 | Force default NaN output |
| clr_i | input | 1 | Clear the sticky invalid flag |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| res_o | output | 32 | Selected and quieted NaN |
| invalid_o | output | 1 | Sticky invalid-operation flag |

## Verification
Each rule is driven with these operand pairs: quiet/quiet, quiet/signaling in both orders, signaling/signaling, and NaN/number. Results that differ between pairs show whether the rule gives priority by position or by kind. For the magnitude rule, NaNs whose significands differ show whether the comparison really takes place. Sign-only twins, applied in both operand orders, isolate the tie-break on the sign. Repeating selected cases with the polarity flipped and with default-NaN mode on shows whether classification, silencing and the flag follow the polarity and survive the override.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;
  typedef enum logic [1:0] {
    RULE_ORDERED   = 2'd0,
    RULE_FIRST     = 2'd1,
    RULE_MAGNITUDE = 2'd2,
    RULE_ALIAS     = 2'd3
  } rule_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_qnan;
  } nan_cls_t;
endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
  import nanprop_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] val_i,
  input  logic                 snan_one_i,
  output nan_cls_t             cls_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  assign exp_f = val_i[EXP_W+MAN_W-1:MAN_W];
  assign man_f = val_i[MAN_W-1:0];

  always_comb begin
    cls_o.is_nan  = (exp_f == '1) && (man_f != '0);
    cls_o.is_snan = cls_o.is_nan && (man_f[MAN_W-1] == snan_one_i);
    cls_o.is_qnan = cls_o.is_nan && (man_f[MAN_W-1] != snan_one_i);
  end
endmodule

// File: rtl/nanprop_pick.sv
module nanprop_pick
  import nanprop_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  nan_cls_t     a_cls_i,
  input  nan_cls_t     b_cls_i,
  input  rule_e        rule_i,
  output logic         pick_b_o
);
  logic a_larger;

  // magnitude first, then positive sign wins a tie
  always_comb begin
    if (a_i[W-2:0] != b_i[W-2:0]) a_larger = a_i[W-2:0] > b_i[W-2:0];
    else                          a_larger = a_i < b_i;
  end

  always_comb begin
    pick_b_o = 1'b1;
    unique case (rule_i)
      RULE_FIRST: pick_b_o = !a_cls_i.is_nan;
      RULE_MAGNITUDE: begin
        if (a_cls_i.is_snan) begin
          if (b_cls_i.is_snan) pick_b_o = !a_larger;
          else                 pick_b_o = b_cls_i.is_qnan;
        end else if (a_cls_i.is_qnan) begin
          if (b_cls_i.is_qnan) pick_b_o = !a_larger;
          else                 pick_b_o = 1'b0;
        end else begin
          pick_b_o = 1'b1;
        end
      end
      default: begin
        if      (a_cls_i.is_snan) pick_b_o = 1'b0;
        else if (b_cls_i.is_snan) pick_b_o = 1'b1;
        else if (a_cls_i.is_qnan) pick_b_o = 1'b0;
        else                      pick_b_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/nanprop_quiet.sv
module nanprop_quiet #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] val_i,
  input  logic                 is_snan_i,
  input  logic                 snan_one_i,
  input  logic                 dnan_en_i,
  output logic [EXP_W+MAN_W:0] res_o
);
  logic [EXP_W+MAN_W:0] dnan;

  always_comb begin
    dnan = '0;
    dnan[EXP_W+MAN_W-1:MAN_W] = '1;
    if (snan_one_i) dnan[MAN_W-2:0] = '1;
    else            dnan[MAN_W-1]   = 1'b1;
  end

  always_comb begin
    res_o = val_i;
    if (dnan_en_i) begin
      res_o = dnan;
    end else if (is_snan_i) begin
      if (snan_one_i) res_o = dnan;
      else            res_o[MAN_W-1] = 1'b1;
    end
  end
endmodule

// File: rtl/nanprop_sel.sv
module nanprop_sel
  import nanprop_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  input  logic [1:0]           rule_i,
  input  logic                 snan_one_i,
  input  logic                 dnan_en_i,
  input  logic                 clr_i,
  output logic                 valid_o,
  output logic [EXP_W+MAN_W:0] res_o,
  output logic                 invalid_o
);
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int N_OPS = 2;

  logic [N_OPS-1:0][W-1:0] ops;
  nan_cls_t [N_OPS-1:0]    cls;
  logic                    pick_b;
  logic [W-1:0]            chosen;
  logic [W-1:0]            res_d;
  logic                    any_snan;

  assign ops[0] = a_i;
  assign ops[1] = b_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    nanprop_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val_i     (ops[g]),
      .snan_one_i(snan_one_i),
      .cls_o     (cls[g])
    );
  end

  nanprop_pick #(.W(W)) u_pick (
    .a_i     (a_i),
    .b_i     (b_i),
    .a_cls_i (cls[0]),
    .b_cls_i (cls[1]),
    .rule_i  (rule_e'(rule_i)),
    .pick_b_o(pick_b)
  );

  assign chosen   = ops[pick_b];
  assign any_snan = cls[0].is_snan | cls[1].is_snan;

  nanprop_quiet #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_quiet (
    .val_i     (chosen),
    .is_snan_i (cls[pick_b].is_snan),
    .snan_one_i(snan_one_i),
    .dnan_en_i (dnan_en_i),
    .res_o     (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_d;
    end
  end

  // a same-cycle raise beats the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  invalid_o <= 1'b0;
    else if (valid_i && any_snan) invalid_o <= 1'b1;
    else if (clr_i)               invalid_o <= 1'b0;
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R2
  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));  // R2
  AST_RES_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (cls[0].is_nan || cls[1].is_nan) |=>
      (res_o[W-2:MAN_W] == '1) && (res_o[MAN_W-1:0] != '0) &&
      (res_o[MAN_W-1] != $past(snan_one_i)));  // R4
  AST_DNAN_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dnan_en_i |=>
      res_o == ($past(snan_one_i) ? {1'b0, {EXP_W{1'b1}}, 1'b0, {(MAN_W-1){1'b1}}}
                                  : {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}}));  // R5
  AST_FLAG_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && any_snan |=> invalid_o);  // R10
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o && !clr_i |=> invalid_o);  // R11
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !(valid_i && any_snan) |=> !invalid_o);  // R11
endmodule

// File: tb/nanprop_sel_tb_top.sv
module nanprop_sel_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [1:0]  rule_i = '0;
  logic        snan_one_i = 1'b0;
  logic        dnan_en_i = 1'b0;
  logic        clr_i = 1'b0;
  logic        valid_o;
  logic [31:0] res_o;
  logic        invalid_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  nanprop_sel dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .rule_i(rule_i), .snan_one_i(snan_one_i), .dnan_en_i(dnan_en_i), .clr_i(clr_i),
    .valid_o(valid_o), .res_o(res_o), .invalid_o(invalid_o)
  );

  localparam logic [31:0] QA  = 32'h7FC0_0001;
  localparam logic [31:0] QB  = 32'h7FC0_0002;
  localparam logic [31:0] SA  = 32'h7F80_0005;
  localparam logic [31:0] SB  = 32'h7F80_0009;
  localparam logic [31:0] NUM = 32'h3F80_0000;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk_i); clr_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0;
  endtask

  // clear, strobe one pair, check result and flag at the next falling edge
  task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] rule, input logic pol, input logic dn,
                        input logic [31:0] exp_res, input logic exp_inv);
    pulse_clear();
    a_i = a; b_i = b; rule_i = rule; snan_one_i = pol; dnan_en_i = dn; valid_i = 1'b1;
    @(negedge clk_i); valid_i = 1'b0;
    chk({tag, " valid"}, {31'd0, valid_o}, 32'd1);
    chk({tag, " res"}, res_o, exp_res);
    chk({tag, " flag"}, {31'd0, invalid_o}, {31'd0, exp_inv});
  endtask

  task automatic t_reset();
    chk("R1 valid", {31'd0, valid_o}, 32'd0);
    chk("R1 res", res_o, 32'd0);
    chk("R1 flag", {31'd0, invalid_o}, 32'd0);
  endtask

  task automatic t_rule0();
    run_op("R6 num/q", NUM, QB, 2'd0, 1'b0, 1'b0, QB, 1'b0);
    run_op("R6 q/s", QA, SB, 2'd0, 1'b0, 1'b0, 32'h7FC0_0009, 1'b1);
    run_op("R6 s/s", SA, SB, 2'd0, 1'b0, 1'b0, 32'h7FC0_0005, 1'b1);
    run_op("R6 q/q", QA, QB, 2'd0, 1'b0, 1'b0, QA, 1'b0);
    run_op("R6 alias", QA, SB, 2'd3, 1'b0, 1'b0, 32'h7FC0_0009, 1'b1);
  endtask

  task automatic t_rule1();
    run_op("R7 q/s", QA, SB, 2'd1, 1'b0, 1'b0, QA, 1'b1);
    run_op("R7 num/s", NUM, SB, 2'd1, 1'b0, 1'b0, 32'h7FC0_0009, 1'b1);
  endtask

  task automatic t_rule2();
    run_op("R8 s/q", SA, QB, 2'd2, 1'b0, 1'b0, QB, 1'b1);
    run_op("R8 q/s", QA, SB, 2'd2, 1'b0, 1'b0, QA, 1'b1);
    run_op("R8 q/q", QA, QB, 2'd2, 1'b0, 1'b0, QB, 1'b0);
    run_op("R8 s/s", SB, SA, 2'd2, 1'b0, 1'b0, 32'h7FC0_0009, 1'b1);
    run_op("R8 num/s", NUM, SA, 2'd2, 1'b0, 1'b0, 32'h7FC0_0005, 1'b1);
    run_op("R8 q/num", QA, NUM, 2'd2, 1'b0, 1'b0, QA, 1'b0);
  endtask

  task automatic t_tie();
    run_op("R9 neg/pos", 32'hFFC0_0003, 32'h7FC0_0003, 2'd2, 1'b0, 1'b0, 32'h7FC0_0003, 1'b0);
    run_op("R9 pos/neg", 32'h7FC0_0003, 32'hFFC0_0003, 2'd2, 1'b0, 1'b0, 32'h7FC0_0003, 1'b0);
  endtask

  task automatic t_polarity();
    run_op("R3 pol1 q/s", SA, QA, 2'd0, 1'b1, 1'b0, 32'h7FBF_FFFF, 1'b1);
    run_op("R4 pol1 q/q", SA, SB, 2'd0, 1'b1, 1'b0, SA, 1'b0);
  endtask

  task automatic t_default();
    run_op("R5 dn quiet", QA, QB, 2'd0, 1'b0, 1'b1, 32'h7FC0_0000, 1'b0);
    run_op("R10 dn snan", SA, QB, 2'd1, 1'b0, 1'b1, 32'h7FC0_0000, 1'b1);
    run_op("R5 dn pol1", QA, NUM, 2'd2, 1'b1, 1'b1, 32'h7FBF_FFFF, 1'b1);
  endtask

  task automatic t_hold();
    run_op("R2 setup", QA, NUM, 2'd1, 1'b0, 1'b0, QA, 1'b0);
    a_i = QB; b_i = SB;
    @(negedge clk_i);
    chk("R2 idle valid", {31'd0, valid_o}, 32'd0);
    chk("R2 idle res", res_o, QA);
  endtask

  task automatic t_sticky();
    run_op("R11 raise", SA, NUM, 2'd0, 1'b0, 1'b0, 32'h7FC0_0005, 1'b1);
    a_i = QA; b_i = QB; valid_i = 1'b1;
    @(negedge clk_i); valid_i = 1'b0;
    chk("R11 stays", {31'd0, invalid_o}, 32'd1);
    @(negedge clk_i);
    chk("R11 idle stays", {31'd0, invalid_o}, 32'd1);
    clr_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0;
    chk("R11 cleared", {31'd0, invalid_o}, 32'd0);
    a_i = SA; b_i = QB; clr_i = 1'b1; valid_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0; valid_i = 1'b0;
    chk("R11 raise wins", {31'd0, invalid_o}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_rule0();
    t_rule1();
    t_rule2();
    t_tie();
    t_polarity();
    t_default();
    t_hold();
    t_sticky();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule